// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block makes the gate pulse that drives an input video clamp, once per scan line. The timing reference is picked by a select input: either the blanking level or the horizontal sync level. Blanking is taken as active-high, and its rising edge starts the pulse. Sync may arrive with either polarity. The block measures how long the sync line stays high and how long it stays low. It treats the shorter of the two phases as the sync pulse and starts the clamp gate when that pulse ends.

The pulse width is chosen by a 2-bit code from four fixed durations. Each duration is converted to a count of system clock cycles at elaboration, from a clock frequency parameter, and rounded to the nearest whole cycle. Both reference inputs are asynchronous to the clock and go through a two-stage synchroniser before any edge is detected.

Top module: `bpcp_gen`

## Requirements
- R1: While reset is high, and in every cycle until a valid trigger edge, `clamp_o` is 0. The level present on an input when reset is released is not treated as an edge.
- R2: With `src_blank_i` = 1, a rising edge on `blank_i` starts a pulse. A falling edge on `blank_i` starts nothing.
- R3: With `src_blank_i` = 0 and sync pulses that are high for less time than they are low (positive sync), a pulse starts on the falling sync edge. The rising sync edge starts nothing.
- R4: With `src_blank_i` = 0 and sync pulses that are low for less time than they are high (negative sync), a pulse starts on the rising sync edge. The falling sync edge starts nothing.
- R5: After reset, no sync-based pulse is produced until one complete high phase and one complete low phase have been measured. The first sync pulse after reset therefore produces no clamp pulse, and the second one does.
- R6: Width code 0 gives round(0.33 us × f), code 1 gives round(0.66 us × f), code 2 gives round(1.0 us × f) and code 3 gives round(1.3 us × f) cycles, where f is the clock frequency. At 50 MHz these are 17, 33, 50 and 65 cycles.
- R7: A trigger edge that arrives while a pulse is active is ignored. It neither extends that pulse nor starts a second one.
- R8: If an input change is first sampled at clock edge k, the pulse is high from clock edge k+2.
- R9: The reference that is not selected has no effect on `clamp_o`.
- R10: The width code is captured when the pulse starts. A change to the code during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_i | input | 1 | Blanking level, asynchronous, active high |
| hsync_i | input | 1 | Horizontal sync level, asynchronous, either polarity |
| src_blank_i | input | 1 | 1 selects blanking as the reference, 0 selects sync |
| width_code_i | input | 2 | Pulse width code (0 to 3) |
| clamp_o | output | 1 | Clamp gate pulse |

## Verification
A wrong polarity decision shows within one line as a clamp pulse that starts on the leading sync edge instead of the trailing one, about 10 cycles early in the test lines. A corrupted width counter shows in the first pulse as a width that differs from the rounded cycle count. A miscounted synchroniser or edge stage shifts every pulse start away from the two-edge latency. A failure to ignore retriggers, or a failure to hold the captured width code, shows inside one pulse as a longer, shorter or doubled gate.

// File: rtl/bpcp_pkg.sv
package bpcp_pkg;

    typedef enum logic [1:0] {
        BPW_SHORT = 2'b00,
        BPW_MED   = 2'b01,
        BPW_LONG  = 2'b10,
        BPW_MAX   = 2'b11
    } bp_width_e;

    typedef enum logic {
        SRC_SYNC  = 1'b0,
        SRC_BLANK = 1'b1
    } bp_src_e;

    // Trigger candidates offered to the source mux.
    typedef struct packed {
        logic blank_rise;
        logic sync_trail;
    } bp_trig_t;

    // Nominal duration in nanoseconds for each width code.
    function automatic int unsigned ns_for_code(logic [1:0] code);
        case (code)
            2'b00:   return 330;
            2'b01:   return 660;
            2'b10:   return 1000;
            default: return 1300;
        endcase
    endfunction

    // Nearest whole clock cycle count for a duration; never below one.
    function automatic int unsigned cycles_for_ns(longint unsigned hz, int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = hz * longint'(ns);
        cyc  = (prod + 64'd500_000_000) / 64'd1_000_000_000;
        if (cyc == 0) return 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/bpcp_sync.sv
module bpcp_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] edge_o
);
    localparam int DEPTH  = STAGES + 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [N-1:0]      chain [DEPTH];
    logic [FILL_W-1:0] fill_q;
    logic              valid;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    // Edges count only once every stage holds a sampled input value.
    always_ff @(posedge clk) begin
        if (rst)                          fill_q <= '0;
        else if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
    end

    assign valid  = (fill_q == FILL_W'(DEPTH));
    assign lvl_o  = chain[STAGES-1];
    assign edge_o = {N{valid}} & (chain[STAGES-1] ^ chain[STAGES]);

endmodule

// File: rtl/bpcp_polarity.sv
module bpcp_polarity #(
    parameter int RUN_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic edge_i,
    output logic trail_o
);
    logic [RUN_W-1:0] run_q, hi_len_q, lo_len_q;
    logic             seen_q, hi_ok_q, lo_ok_q;
    logic             high_ended;

    // New level low means a high phase just ended.
    assign high_ended = !lvl_i;

    always_comb begin
        trail_o = 1'b0;
        if (edge_i && seen_q) begin
            if (high_ended) trail_o = lo_ok_q && (run_q <  lo_len_q);
            else            trail_o = hi_ok_q && (run_q <= hi_len_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            hi_len_q <= '0;
            lo_len_q <= '0;
            seen_q   <= 1'b0;
            hi_ok_q  <= 1'b0;
            lo_ok_q  <= 1'b0;
        end else if (edge_i) begin
            run_q  <= '0;
            seen_q <= 1'b1;
            if (high_ended) begin
                hi_len_q <= run_q;
                hi_ok_q  <= hi_ok_q | seen_q;
            end else begin
                lo_len_q <= run_q;
                lo_ok_q  <= lo_ok_q | seen_q;
            end
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    p_history_before_trigger_r5: assert property (@(posedge clk) disable iff (rst)
        trail_o |-> $past(seen_q));

    p_run_saturates_r5: assert property (@(posedge clk) disable iff (rst)
        (run_q == '1 && !edge_i) |=> (run_q == '1));

endmodule

// File: rtl/bpcp_pulse.sv
module bpcp_pulse
    import bpcp_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  logic [1:0] code_i,
    output logic       pulse_o
);
    localparam int unsigned W_MAX = cycles_for_ns(CLK_HZ, ns_for_code(BPW_MAX));
    localparam int CNT_W = $clog2(W_MAX + 1);

    logic [CNT_W-1:0] lut [4];
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    for (genvar i = 0; i < 4; i++) begin : g_lut
        assign lut[i] = CNT_W'(cycles_for_ns(CLK_HZ, ns_for_code(2'(i))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else if (pulse_q) begin
            if (cnt_q == '0) pulse_q <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end else if (trig_i) begin
            pulse_q <= 1'b1;
            cnt_q   <= lut[code_i] - 1'b1;
        end
    end

    assign pulse_o = pulse_q;

    p_start_needs_trigger_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(trig_i));

    p_retrigger_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && cnt_q != '0) |=> (pulse_q && cnt_q == $past(cnt_q) - 1'b1));

    p_end_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_q) |-> ($past(cnt_q) == '0));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (32'(cnt_q) < W_MAX));

endmodule

// File: rtl/bpcp_gen.sv
module bpcp_gen
    import bpcp_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 50_000_000,
    parameter int              RUN_W       = 12,
    parameter int              SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       blank_i,
    input  logic       hsync_i,
    input  logic       src_blank_i,
    input  logic [1:0] width_code_i,
    output logic       clamp_o
);
    localparam int IDX_BLANK = 0;
    localparam int IDX_SYNC  = 1;

    logic [1:0] lvl, edg;
    bp_trig_t   trig;
    bp_src_e    src;
    logic       fire;

    bpcp_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({hsync_i, blank_i}),
        .lvl_o  (lvl),
        .edge_o (edg)
    );

    bpcp_polarity #(.RUN_W(RUN_W)) u_pol (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   (lvl[IDX_SYNC]),
        .edge_i  (edg[IDX_SYNC]),
        .trail_o (trig.sync_trail)
    );

    assign trig.blank_rise = edg[IDX_BLANK] & lvl[IDX_BLANK];
    assign src  = bp_src_e'(src_blank_i);
    assign fire = (src == SRC_BLANK) ? trig.blank_rise : trig.sync_trail;

    bpcp_pulse #(.CLK_HZ(CLK_HZ)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (fire),
        .code_i  (width_code_i),
        .pulse_o (clamp_o)
    );

    p_blank_fall_inert_r2: assert property (@(posedge clk) disable iff (rst)
        (src_blank_i && edg[IDX_BLANK] && !lvl[IDX_BLANK] && !clamp_o) |=> !clamp_o);

endmodule

// File: tb/bpcp_gen_test.sv
module bpcp_gen_test;
    localparam int ACT  = 10;
    localparam int IDLE = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blk = 1'b0;
    logic       hs  = 1'b0;
    logic       sel = 1'b1;
    logic [1:0] code = 2'b00;
    logic       pulse;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bpcp_gen #(.CLK_HZ(50_000_000)) uut (
        .clk          (clk),
        .rst          (rst),
        .blank_i      (blk),
        .hsync_i      (hs),
        .src_blank_i  (sel),
        .width_code_i (code),
        .clamp_o      (pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_w(input int c);
        longint ns;
        ns = (c == 0) ? 330 : (c == 1) ? 660 : (c == 2) ? 1000 : 1300;
        return int'((64'd50_000 * ns + 64'd500_000) / 64'd1_000_000);
    endfunction

    task automatic do_reset(input logic idle_hs);
        @(negedge clk);
        rst = 1'b1;
        hs  = idle_hs;
        blk = 1'b0;
        repeat (4) @(negedge clk);
        chk(pulse == 1'b0, "R1 low in reset", int'(pulse), 0);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        chk(pulse == 1'b0, "R1 low after reset", int'(pulse), 0);
    endtask

    task automatic quiet(input int n, input string req);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Called at the negedge where the trigger level was just driven.
    task automatic observe(input int w, input string req, output int used);
        int n = 0;
        repeat (2) @(negedge clk);
        chk(pulse == 1'b0, "R8 not yet high", int'(pulse), 0);
        @(negedge clk);
        chk(pulse == 1'b1, {"R8 start ", req}, int'(pulse), 1);
        while (pulse && n < 500) begin
            n++;
            @(negedge clk);
        end
        chk(n == w, "R6 width", n, w);
        used = 3 + n;
    endtask

    task automatic hs_line(input logic pos, input bit expect_p, input int w, input string req);
        int used = 0;
        hs = pos;
        quiet(ACT, {req, " leading edge inert"});
        hs = ~pos;
        if (expect_p) observe(w, req, used);
        quiet(IDLE - used, {req, " quiet after line"});
    endtask

    task automatic blk_line(input int w);
        int used;
        blk = 1'b1;
        observe(w, "R2", used);
        blk = 1'b0;
        quiet(40, "R2 falling edge inert");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Sweep: reference kind x width code.
        for (int cfg = 0; cfg < 3; cfg++) begin
            for (int c = 0; c < 4; c++) begin
                code = 2'(c);
                sel  = (cfg == 0);
                do_reset(cfg == 2);
                if (cfg == 0) begin
                    repeat (3) blk_line(exp_w(c));
                end else begin
                    string tag;
                    tag = (cfg == 1) ? "R3" : "R4";
                    hs_line(cfg == 1, 1'b0, 0, "R5 first sync pulse");
                    repeat (3) hs_line(cfg == 1, 1'b1, exp_w(c), tag);
                end
            end
        end

        // R7 and R10: retrigger during a pulse, code change during a pulse.
        begin
            int hi = 1;
            sel  = 1'b1;
            code = 2'b11;
            do_reset(1'b0);
            blk = 1'b1;
            repeat (2) @(negedge clk);
            @(negedge clk);
            chk(pulse == 1'b1, "R7 pulse started", int'(pulse), 1);
            repeat (5) begin @(negedge clk); hi += int'(pulse); end
            blk = 1'b0;
            repeat (5) begin @(negedge clk); hi += int'(pulse); end
            blk  = 1'b1;
            code = 2'b00;
            while (pulse && hi < 500) begin
                @(negedge clk);
                hi += int'(pulse);
            end
            chk(hi == exp_w(3), "R7 R10 width kept", hi, exp_w(3));
            quiet(60, "R7 no second pulse");
            blk = 1'b0;
            quiet(20, "R7 quiet");
        end

        // R9: unselected reference ignored.
        sel  = 1'b1;
        code = 2'b01;
        do_reset(1'b0);
        repeat (3) hs_line(1'b1, 1'b0, 0, "R9 sync ignored");
        sel = 1'b0;
        do_reset(1'b0);
        repeat (3) begin
            blk = 1'b1;
            quiet(20, "R9 blank rise ignored");
            blk = 1'b0;
            quiet(40, "R9 blank fall ignored");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule